// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide flash memory model. Each write strobe brings a 17-bit address and a data byte. The block follows the multi-cycle unlock sequences that guard the array and tracks how far a sequence has got. When a sequence completes, it raises a single-cycle request to the array and timing logic. The four requests are: return to read mode, program one byte, erase the whole chip, or erase one sector.

While no sequence is in progress, the block reports read mode, so reads return array data; no command is needed after power-up. Writes are dropped while the array logic reports that an embedded operation is busy. A supply-low lockout input forces read mode and rejects all writes for as long as it is held.

Every write is one clock cycle with the strobe high. The address and the data are both sampled on that cycle, which stands for the start and the end of the external write pulse. Only the low 15 address bits take part in the unlock and command address compares.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is held and on the first cycle after its release, read_mode is 1 and all four request outputs are 0.
- R2: A command opens with data AAh at an address whose low 15 bits are 5555h, then data 55h at low 15 bits 2AAAh; address bits 15 and 16 never affect these compares.
- R3: A third write of F0h at low bits 5555h pulses req_reset for one cycle, the cycle after that write; read_mode is 1 from that cycle on.
- R4: A third write of A0h at low bits 5555h arms programming; the next accepted write, at any address, pulses req_prog, with prog_addr holding all 17 address bits and prog_data holding the byte of that write.
- R5: A third write of 80h at low bits 5555h, then AAh at 5555h, 55h at 2AAAh, and 10h at 5555h (low 15 bits each), pulses req_chip_erase.
- R6: After the same five erase cycles, a sixth write of 30h at any address pulses req_sector_erase, with sector_num equal to address bits 16..14 of that write.
- R7: Any accepted write that does not match the expected next cycle returns the decoder to read mode and raises no request.
- R8: A write presented while busy is 1 is dropped: it raises no request and leaves the sequence position unchanged, so that a sequence interrupted by it still completes.
- R9: While lockout is 1, read_mode is 1 from the next cycle, any partial sequence is lost, and writes raise no request.
- R10: read_mode is 0 while a sequence is partly received. Requests are single-cycle pulses, at most one at a time, and each follows an accepted write one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Embedded operation in progress; writes dropped |
| lockout | input | 1 | Supply-low lockout; forces read mode, rejects writes |
| read_mode | output | 1 | No command sequence is in progress |
| req_reset | output | 1 | Read/reset command pulse |
| req_prog | output | 1 | Program-byte request pulse |
| prog_addr | output | 17 | Address to program, valid with req_prog |
| prog_data | output | 8 | Byte to program, valid with req_prog |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| sector_num | output | 3 | Sector to erase, valid with req_sector_erase |

## Verification
A wrong sequence position shows at the ports in one of two ways. If read_mode is wrong, it shows one cycle after the write that caused the error. Otherwise the error stays hidden until a later write: that write then produces a missing, extra or wrong request, as late as the sixth cycle of an erase sequence. For that reason the bench compares every output on every cycle against a reference model. The random sequences are corrupted, broken up by busy writes and lockout, and use random values on the ignored upper address bits. This exposes a skipped state, a compare that looks at a bit it should ignore, or a dropped write that still moves the sequence on, soon after the point where it first differs.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 15,
  parameter int SECT_W = 3,
  parameter logic [CMP_W-1:0]  UNLK_ADDR_1 = 15'h5555,
  parameter logic [CMP_W-1:0]  UNLK_ADDR_2 = 15'h2AAA,
  parameter logic [DATA_W-1:0] UNLK_DATA_1 = 8'hAA,
  parameter logic [DATA_W-1:0] UNLK_DATA_2 = 8'h55,
  parameter logic [DATA_W-1:0] OP_RESET    = 8'hF0,
  parameter logic [DATA_W-1:0] OP_PROG     = 8'hA0,
  parameter logic [DATA_W-1:0] OP_ERASE    = 8'h80,
  parameter logic [DATA_W-1:0] OP_CHIP     = 8'h10,
  parameter logic [DATA_W-1:0] OP_SECTOR   = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              lockout,
  output logic              read_mode,
  output logic              req_reset,
  output logic              req_prog,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              req_chip_erase,
  output logic              req_sector_erase,
  output logic [SECT_W-1:0] sector_num
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  typedef enum logic [2:0] {
    ST_READ, ST_UNLK1, ST_UNLK2, ST_PROG, ST_ERS0, ST_ERS1, ST_ERS2
  } seq_t;

  seq_t seq_q, seq_d;
  logic go_reset, go_prog, go_chip, go_sector;

  wire take  = wr_en & ~busy & ~lockout;
  wire at_a1 = (wr_addr[CMP_W-1:0] == UNLK_ADDR_1);
  wire at_a2 = (wr_addr[CMP_W-1:0] == UNLK_ADDR_2);
  wire unl1  = at_a1 && (wr_data == UNLK_DATA_1);
  wire unl2  = at_a2 && (wr_data == UNLK_DATA_2);

  always_comb begin
    seq_d     = seq_q;
    go_reset  = 1'b0;
    go_prog   = 1'b0;
    go_chip   = 1'b0;
    go_sector = 1'b0;
    if (take) begin
      seq_d = ST_READ;
      unique case (seq_q)
        ST_READ:  if (unl1) seq_d = ST_UNLK1;
        ST_UNLK1: if (unl2) seq_d = ST_UNLK2;
        ST_UNLK2: if (at_a1) begin
          if (wr_data == OP_RESET)      go_reset = 1'b1;
          else if (wr_data == OP_PROG)  seq_d = ST_PROG;
          else if (wr_data == OP_ERASE) seq_d = ST_ERS0;
        end
        ST_PROG:  go_prog = 1'b1;
        ST_ERS0:  if (unl1) seq_d = ST_ERS1;
        ST_ERS1:  if (unl2) seq_d = ST_ERS2;
        ST_ERS2: begin
          if (at_a1 && wr_data == OP_CHIP) go_chip = 1'b1;
          else if (wr_data == OP_SECTOR)   go_sector = 1'b1;
        end
        default: seq_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q            <= ST_READ;
      req_reset        <= 1'b0;
      req_prog         <= 1'b0;
      req_chip_erase   <= 1'b0;
      req_sector_erase <= 1'b0;
      prog_addr        <= '0;
      prog_data        <= '0;
      sector_num       <= '0;
    end else begin
      seq_q            <= lockout ? ST_READ : seq_d;
      req_reset        <= go_reset;
      req_prog         <= go_prog;
      req_chip_erase   <= go_chip;
      req_sector_erase <= go_sector;
      if (go_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (go_sector) sector_num <= wr_addr[ADDR_W-1:SECT_LSB];
    end
  end

  assign read_mode = (seq_q == ST_READ);
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic busy,
  input logic lockout,
  input logic read_mode,
  input logic req_reset,
  input logic req_prog,
  input logic req_chip_erase,
  input logic req_sector_erase
);
  wire any_req = req_reset | req_prog | req_chip_erase | req_sector_erase;

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (read_mode && !any_req)
      else $error("reset state wrong");
  end

  assert_one_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_reset, req_prog, req_chip_erase, req_sector_erase}));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);

  assert_req_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> $past(wr_en));

  assert_req_read_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> read_mode);

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !wr_en) |=> !any_req);

  assert_lockout_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> (read_mode && !any_req));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .lockout(lockout),
  .read_mode(read_mode), .req_reset(req_reset), .req_prog(req_prog),
  .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        lockout = 1'b0;
  logic        read_mode, req_reset, req_prog, req_chip_erase, req_sector_erase;
  logic [16:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  sector_num;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int          m_st = 0;
  logic        e_rm = 1'b1, e_rst = 1'b0, e_prg = 1'b0, e_chip = 1'b0, e_sec = 1'b0;
  logic [16:0] e_pa = '0;
  logic [7:0]  e_pd = '0;
  logic [2:0]  e_sn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .lockout(lockout), .read_mode(read_mode), .req_reset(req_reset),
    .req_prog(req_prog), .prog_addr(prog_addr), .prog_data(prog_data),
    .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
    .sector_num(sector_num)
  );

  function automatic bit is_a(input logic [16:0] a); return a[14:0] == 15'h5555; endfunction
  function automatic bit is_b(input logic [16:0] a); return a[14:0] == 15'h2AAA; endfunction

  // Reference: 0 read, 1/2 unlocked, 3 program armed, 4/5/6 erase path
  task automatic model(input logic we, input logic [16:0] a, input logic [7:0] d,
                       input logic b, input logic lk);
    int nx;
    e_rst = 0; e_prg = 0; e_chip = 0; e_sec = 0;
    nx = m_st;
    if (lk) nx = 0;
    else if (we && !b) begin
      nx = 0;
      case (m_st)
        0: if (is_a(a) && d == 8'hAA) nx = 1;
        1: if (is_b(a) && d == 8'h55) nx = 2;
        2: if (is_a(a)) begin
             if (d == 8'hF0) e_rst = 1;
             else if (d == 8'hA0) nx = 3;
             else if (d == 8'h80) nx = 4;
           end
        3: begin e_prg = 1; e_pa = a; e_pd = d; end
        4: if (is_a(a) && d == 8'hAA) nx = 5;
        5: if (is_b(a) && d == 8'h55) nx = 6;
        6: if (is_a(a) && d == 8'h10) e_chip = 1;
           else if (d == 8'h30) begin e_sec = 1; e_sn = a[16:14]; end
        default: nx = 0;
      endcase
    end
    m_st = nx;
    e_rm = (m_st == 0);
  endtask

  task automatic chk(input string tag, input string nm, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h expected %0h", tag, nm, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "read_mode", 32'(read_mode), 32'(e_rm));
    chk(tag, "req_reset", 32'(req_reset), 32'(e_rst));
    chk(tag, "req_prog", 32'(req_prog), 32'(e_prg));
    chk(tag, "req_chip_erase", 32'(req_chip_erase), 32'(e_chip));
    chk(tag, "req_sector_erase", 32'(req_sector_erase), 32'(e_sec));
    if (e_prg) begin
      chk(tag, "prog_addr", 32'(prog_addr), 32'(e_pa));
      chk(tag, "prog_data", 32'(prog_data), 32'(e_pd));
    end
    if (e_sec) chk(tag, "sector_num", 32'(sector_num), 32'(e_sn));
  endtask

  task automatic cyc(input string tag, input logic we, input logic [16:0] a,
                     input logic [7:0] d, input logic b, input logic lk);
    wr_en = we; wr_addr = a; wr_data = d; busy = b; lockout = lk;
    model(we, a, d, b, lk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic wr(input string tag, input logic [16:0] a, input logic [7:0] d);
    cyc(tag, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  function automatic logic [16:0] cmd_addr(input logic [14:0] low);
    return {2'($urandom), low};
  endfunction

  task automatic rnd_wr(input logic [16:0] a, input logic [7:0] d);
    int r;
    r = int'($urandom % 100);
    if (r < 6) cyc("R8 random busy", 1'b1, 17'($urandom), 8'($urandom), 1'b1, 1'b0);
    else if (r < 8) cyc("R9 random lockout", 1'($urandom), 17'($urandom), 8'($urandom), 1'($urandom), 1'b1);
    else if (r < 14) cyc("R10 random gap", 1'b0, 17'($urandom), 8'($urandom), 1'($urandom), 1'b0);
    r = int'($urandom % 100);
    if (r < 7) wr("R7 random corrupt", a ^ 17'(1 << ($urandom % 15)), d);
    else if (r < 10) wr("R7 random data", a, 8'($urandom));
    else wr("R10 random seq", a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R10 got timeout expected completion");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    // R2/R3: reset command with ignored bits 15 and 16 set
    wr("R2 unlock1 hi bits", 17'h1D555, 8'hAA);
    wr("R2 unlock2 hi bits", 17'h0AAAA, 8'h55);
    wr("R3 reset cmd", 17'h15555, 8'hF0);
    cyc("R3 after", 1'b0, '0, '0, 1'b0, 1'b0);

    // R4 program
    wr("R4 u1", 17'h05555, 8'hAA);
    wr("R4 u2", 17'h02AAA, 8'h55);
    wr("R4 setup", 17'h05555, 8'hA0);
    wr("R4 program", 17'h1ABCD, 8'h5A);
    cyc("R4 pulse end", 1'b0, '0, '0, 1'b0, 1'b0);

    // R5 chip erase
    wr("R5 c1", 17'h05555, 8'hAA);
    wr("R5 c2", 17'h02AAA, 8'h55);
    wr("R5 c3", 17'h05555, 8'h80);
    wr("R5 c4", 17'h0D555, 8'hAA);
    wr("R5 c5", 17'h02AAA, 8'h55);
    wr("R5 chip", 17'h1D555, 8'h10);

    // R6 sector erase, sectors 7 and 1
    wr("R6 s1", 17'h05555, 8'hAA);
    wr("R6 s2", 17'h02AAA, 8'h55);
    wr("R6 s3", 17'h05555, 8'h80);
    wr("R6 s4", 17'h05555, 8'hAA);
    wr("R6 s5", 17'h02AAA, 8'h55);
    wr("R6 sector7", 17'h1C123, 8'h30);
    wr("R6 t1", 17'h05555, 8'hAA);
    wr("R6 t2", 17'h02AAA, 8'h55);
    wr("R6 t3", 17'h05555, 8'h80);
    wr("R6 t4", 17'h05555, 8'hAA);
    wr("R6 t5", 17'h02AAA, 8'h55);
    wr("R6 sector1", 17'h04000, 8'h30);

    // R7 bad second unlock address, then a would-be command
    wr("R7 u1", 17'h05555, 8'hAA);
    wr("R7 bad u2", 17'h02AAB, 8'h55);
    wr("R7 no cmd", 17'h05555, 8'hF0);
    // R7 wrong sixth byte
    wr("R7 e1", 17'h05555, 8'hAA);
    wr("R7 e2", 17'h02AAA, 8'h55);
    wr("R7 e3", 17'h05555, 8'h80);
    wr("R7 e4", 17'h05555, 8'hAA);
    wr("R7 e5", 17'h02AAA, 8'h55);
    wr("R7 bad sixth", 17'h05555, 8'h20);

    // R8 busy write mid-sequence is dropped, sequence completes
    wr("R8 u1", 17'h05555, 8'hAA);
    wr("R8 u2", 17'h02AAA, 8'h55);
    cyc("R8 busy junk", 1'b1, 17'h00001, 8'h00, 1'b1, 1'b0);
    wr("R8 setup", 17'h05555, 8'hA0);
    cyc("R8 busy prog", 1'b1, 17'h00777, 8'h11, 1'b1, 1'b0);
    wr("R8 program", 17'h00778, 8'h22);

    // R9 lockout mid-sequence, then writes under lockout
    wr("R9 u1", 17'h05555, 8'hAA);
    wr("R9 u2", 17'h02AAA, 8'h55);
    cyc("R9 lock", 1'b0, '0, '0, 1'b0, 1'b1);
    cyc("R9 locked wr1", 1'b1, 17'h05555, 8'hAA, 1'b0, 1'b1);
    cyc("R9 locked wr2", 1'b1, 17'h02AAA, 8'h55, 1'b0, 1'b1);
    wr("R9 released", 17'h05555, 8'hF0);

    for (int i = 0; i < 900; i++) begin
      int k;
      k = int'($urandom % 4);
      rnd_wr(cmd_addr(15'h5555), 8'hAA);
      rnd_wr(cmd_addr(15'h2AAA), 8'h55);
      case (k)
        0: rnd_wr(cmd_addr(15'h5555), 8'hF0);
        1: begin
          rnd_wr(cmd_addr(15'h5555), 8'hA0);
          rnd_wr(17'($urandom), 8'($urandom));
        end
        default: begin
          rnd_wr(cmd_addr(15'h5555), 8'h80);
          rnd_wr(cmd_addr(15'h5555), 8'hAA);
          rnd_wr(cmd_addr(15'h2AAA), 8'h55);
          if (k == 2) rnd_wr(cmd_addr(15'h5555), 8'h10);
          else rnd_wr(17'($urandom), 8'h30);
        end
      endcase
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule